// File: doc/BRIEF.md
# Cascaded Segment Row Loader

This block is the input path of one chip in a chain of column drivers for a dot-matrix panel. Pixel data arrives on a parallel bus. In wide mode each beat carries 8 pixels. In narrow mode each beat carries 4 pixels, and two beats make one byte. Complete bytes are written into a row-wide data latch through a pointer that moves one 16-column group for every two bytes.

A chip loads data only while its cascade enable input is held low by the chip before it. When all of its columns are written, the chip drives its own cascade enable output low, drops `din_ready`, and ignores any further beats. The enable output stays low until the next line pulse.

On the falling edge of the line pulse, the row held in the data latch is copied into the line latch in a single cycle. The same edge returns the loading logic to its start state. A direction select chooses one of two things together: whether the row fills from the lowest column or from the highest, and which of the two enable pin pairs serves as input and which as output.

The bus uses a valid/ready handshake. A beat is taken in a cycle where both `din_valid` and `din_ready` are high. The source may hold `din_valid` high for as long as it likes. `din_ready` is high only while the chip is selected, its row is not yet full, and the current cycle is not a line-pulse falling edge. A beat offered while `din_ready` is low is not consumed, and the source must keep it until `din_ready` returns.

Top module: `seg_line_loader`

## Requirements
- R1: After reset, `line_q` is all zero, both cascade outputs are high, and `din_ready` is low while the active cascade input is high.
- R2: In wide mode (`wide_mode`=1) each accepted beat is one byte. With `rev_dir`=0, the k-th byte of a line (k from 0) lands in `line_q[8k+j]` = byte bit 7-j, so its bit 7 lands in the lowest column.
- R3: In narrow mode (`wide_mode`=0) only `din[3:0]` is used. The first accepted beat of a pair becomes the upper nibble of the byte, and the second becomes the lower nibble.
- R4: With `rev_dir`=1 the k-th byte lands in `line_q[152-8k+b]` = byte bit b. The cascade input is `casc_b_n_i` and the output is `casc_a_n_o`. With `rev_dir`=0 the input is `casc_a_n_i` and the output is `casc_b_n_o`. The output pin not in use stays high.
- R5: `din_ready` is high only while the active cascade input is low and fewer than 20 bytes have been written since the last line pulse. After the 20th byte the active cascade output goes low in the next cycle, and later beats change nothing.
- R6: A cascade output that has gone low stays low until a line-pulse falling edge, then returns high. That edge also resets the byte position to 0 and the narrow-mode nibble phase to "upper".
- R7: The line latch changes only on a line-pulse falling edge, meaning a cycle in which `lp` is sampled low after being sampled high, or under R8. At that edge it takes the data latch as it stands. Columns not rewritten since the previous line keep their old data.
- R8: In every cycle in which `disp_off_n` is sampled low, `line_q` is cleared on the following edge. It does this even if a line-pulse falling edge occurs at the same time.
- R9: The write pointer moves to the next 16-column group after every second byte. The two bytes of a group fill that group's lower and then upper 8 columns in fill order.
- R10: `din_ready` is low in the cycle of a line-pulse falling edge, and no beat is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 8 | Pixel bus; only [3:0] is used in narrow mode |
| din_valid | input | 1 | Beat offered on `din` |
| din_ready | output | 1 | Beat can be taken this cycle |
| wide_mode | input | 1 | 1 = 8-bit beats, 0 = 4-bit beats |
| rev_dir | input | 1 | 0 = fill from lowest column, 1 = from highest |
| lp | input | 1 | Line pulse; acts on its falling edge |
| casc_a_n_i | input | 1 | Cascade enable in, pair A (used when `rev_dir`=0) |
| casc_b_n_i | input | 1 | Cascade enable in, pair B (used when `rev_dir`=1) |
| casc_a_n_o | output | 1 | Cascade enable out, pair A (used when `rev_dir`=1) |
| casc_b_n_o | output | 1 | Cascade enable out, pair B (used when `rev_dir`=0) |
| disp_off_n | input | 1 | Active-low display off; clears the line latch |
| line_q | output | 160 | Line latch, bit i = column i+1 |

## Verification
The assertions take for granted that `wide_mode` and `rev_dir` stay fixed while a line is being loaded, and that `lp` is a level that the shift clock samples. The stimulus changes the two selects only between line pulses. It holds `lp` high for at least one whole cycle before each fall. It drives every input on the falling clock edge, so each sampled value is clean.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = 4;

  // Mirror the bits of one byte (bit 7 <-> bit 0).
  function automatic logic [BYTE_W-1:0] bit_rev8(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/seg_nibble_packer.sv
module seg_nibble_packer
  import seg_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wide,
  input  logic              take,
  input  logic [BYTE_W-1:0] din,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_q
);
  logic             phase;   // 1 = upper nibble already held
  logic [NIB_W-1:0] hi_nib;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= 1'b0;
      hi_nib <= '0;
    end else if (clr) begin
      phase  <= 1'b0;
    end else if (take && !wide) begin
      phase <= ~phase;
      if (!phase) hi_nib <= din[NIB_W-1:0];
    end
  end

  always_comb begin
    byte_vld = take && (wide || phase);
    byte_q   = wide ? din : {hi_nib, din[NIB_W-1:0]};
  end

  // R3
  nibble_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wide && !phase && !clr) |=> (phase || clr));
endmodule

// File: rtl/seg_group_ptr.sv
module seg_group_ptr #(
  parameter int unsigned NGROUPS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 step,
  output logic [2*NGROUPS-1:0] slot_en,
  output logic                 full
);
  logic [NGROUPS-1:0] grp;
  logic               half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp  <= NGROUPS'(1);
      half <= 1'b0;
    end else if (clr) begin
      grp  <= NGROUPS'(1);
      half <= 1'b0;
    end else if (step && !full) begin
      if (half) begin
        grp  <= grp << 1;
        half <= 1'b0;
      end else begin
        half <= 1'b1;
      end
    end
  end

  assign full = ~|grp;

  for (genvar g = 0; g < NGROUPS; g++) begin : g_slot
    assign slot_en[2*g]   = grp[g] & ~half;
    assign slot_en[2*g+1] = grp[g] &  half;
  end

  // R9
  grp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp));

  // R9
  grp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(grp));
endmodule

// File: rtl/seg_data_latch.sv
module seg_data_latch
  import seg_loader_pkg::*;
#(
  parameter int unsigned COLS = 160,
  localparam int unsigned NB = COLS / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rev,
  input  logic [NB-1:0]     slot_en,
  input  logic [BYTE_W-1:0] byte_d,
  output logic [COLS-1:0]   latch_q
);
  // Slice s owns columns BYTE_W*s .. BYTE_W*s+7; it is written by slot s
  // when filling upward, or by slot NB-1-s when filling downward.
  for (genvar s = 0; s < NB; s++) begin : g_slice
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        latch_q[BYTE_W*s +: BYTE_W] <= '0;
      end else if (wr) begin
        if (!rev && slot_en[s])
          latch_q[BYTE_W*s +: BYTE_W] <= bit_rev8(byte_d);
        else if (rev && slot_en[NB-1-s])
          latch_q[BYTE_W*s +: BYTE_W] <= byte_d;
      end
    end
  end
endmodule

// File: rtl/seg_line_loader.sv
module seg_line_loader
  import seg_loader_pkg::*;
#(
  parameter int unsigned COLS    = 160,
  parameter int unsigned GROUP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        din,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic              wide_mode,
  input  logic              rev_dir,
  input  logic              lp,
  input  logic              casc_a_n_i,
  input  logic              casc_b_n_i,
  output logic              casc_a_n_o,
  output logic              casc_b_n_o,
  input  logic              disp_off_n,
  output logic [COLS-1:0]   line_q
);
  localparam int unsigned NB = COLS / BYTE_W;
  localparam int unsigned NG = COLS / GROUP_W;

  logic              lp_d, lp_fall, casc_in_n, casc_out_n, full, take, byte_vld;
  logic [NB-1:0]     slot_en;
  logic [BYTE_W-1:0] byte_q;
  logic [COLS-1:0]   latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lp_d <= 1'b0;
    else        lp_d <= lp;
  end

  always_comb begin
    lp_fall    = lp_d & ~lp;
    casc_in_n  = rev_dir ? casc_b_n_i : casc_a_n_i;
    din_ready  = ~casc_in_n & ~full & ~lp_fall;
    take       = din_valid & din_ready;
    casc_out_n = ~full;
    casc_a_n_o = rev_dir ? casc_out_n : 1'b1;
    casc_b_n_o = rev_dir ? 1'b1 : casc_out_n;
  end

  seg_nibble_packer u_pack (
    .clk(clk), .rst_n(rst_n), .clr(lp_fall), .wide(wide_mode), .take(take),
    .din(din), .byte_vld(byte_vld), .byte_q(byte_q)
  );

  seg_group_ptr #(.NGROUPS(NG)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(lp_fall), .step(byte_vld),
    .slot_en(slot_en), .full(full)
  );

  seg_data_latch #(.COLS(COLS)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr(byte_vld), .rev(rev_dir),
    .slot_en(slot_en), .byte_d(byte_q), .latch_q(latch_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          line_q <= '0;
    else if (!disp_off_n) line_q <= '0;
    else if (lp_fall)    line_q <= latch_q;
  end

  // R5
  no_load_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !din_ready);

  // R6
  casc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!casc_out_n && !lp_fall) |=> !casc_out_n);

  // R8
  dispoff_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_off_n |=> (line_q == '0));

  // R7
  line_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_off_n && !lp_fall) |=> $stable(line_q));

  // R10
  no_take_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lp_fall |-> !take);
endmodule

// File: tb/seg_line_loader_test.sv
module seg_line_loader_test;
  localparam int COLS = 160;
  localparam int NB   = COLS / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] din = '0;
  logic din_valid = 1'b0, wide_mode = 1'b1, rev_dir = 1'b0, lp = 1'b0;
  logic casc_a_n_i = 1'b1, casc_b_n_i = 1'b1, disp_off_n = 1'b1;
  logic din_ready, casc_a_n_o, casc_b_n_o;
  logic [COLS-1:0] line_q;

  always #2.5 clk = ~clk;

  seg_line_loader #(.COLS(COLS), .GROUP_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .din(din), .din_valid(din_valid),
    .din_ready(din_ready), .wide_mode(wide_mode), .rev_dir(rev_dir), .lp(lp),
    .casc_a_n_i(casc_a_n_i), .casc_b_n_i(casc_b_n_i),
    .casc_a_n_o(casc_a_n_o), .casc_b_n_o(casc_b_n_o),
    .disp_off_n(disp_off_n), .line_q(line_q)
  );

  int n_chk = 0, n_fail = 0;
  logic [COLS-1:0] m_latch = '0;
  logic [COLS-1:0] exp_q[$];
  int  m_slot = 0;
  logic m_phase = 1'b0;
  logic [3:0] m_hi = '0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req,
                       input logic [COLS-1:0] act, input logic [COLS-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench model of where a finished byte goes (R2, R4, R9).
  task automatic place(input logic [7:0] b);
    for (int j = 0; j < 8; j++) begin
      if (!rev_dir) m_latch[8*m_slot + j] = b[7-j];
      else          m_latch[COLS-8-8*m_slot + j] = b[j];
    end
    m_slot++;
  endtask

  task automatic beat(input logic [7:0] d);
    logic cin;
    @(negedge clk);
    din = d; din_valid = 1'b1;
    #1;
    cin = rev_dir ? casc_b_n_i : casc_a_n_i;
    check(din_ready == (!cin && m_slot < NB), "R5 ready", COLS'(din_ready),
          COLS'(!cin && m_slot < NB));
    if (din_ready) begin
      if (wide_mode) place(d);
      else if (!m_phase) begin m_hi = d[3:0]; m_phase = 1'b1; end
      else begin place({m_hi, d[3:0]}); m_phase = 1'b0; end
    end
    @(posedge clk); #1;
    din_valid = 1'b0;
  endtask

  task automatic line_pulse();
    @(negedge clk); lp = 1'b1;
    @(negedge clk); lp = 1'b0;
    #1;
    // R10: no take in the falling-edge cycle
    check(din_ready == 1'b0, "R10", COLS'(din_ready), '0);
    exp_q.push_back(disp_off_n ? m_latch : '0);
    m_slot = 0; m_phase = 1'b0;
    @(posedge clk); #2;
    // R6: cascade outputs released
    check(casc_a_n_o && casc_b_n_o, "R6 release",
          COLS'({casc_a_n_o, casc_b_n_o}), COLS'(2'b11));
  endtask

  // Monitor: compares the line latch after every capture edge (R7).
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        logic [COLS-1:0] e;
        e = exp_q.pop_front();
        check(line_q == e, "R7 line", line_q, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1
    check(line_q == '0, "R1 line", line_q, '0);
    check(casc_a_n_o && casc_b_n_o, "R1 casc", COLS'({casc_a_n_o, casc_b_n_o}), COLS'(2'b11));
    check(!din_ready, "R1 ready", COLS'(din_ready), '0);

    // R2 wide, upward fill, then ignored beats (R5)
    casc_a_n_i = 1'b0; wide_mode = 1'b1; rev_dir = 1'b0;
    for (int k = 0; k < NB; k++) beat(8'(k * 37 + 5));
    check(casc_b_n_o == 1'b0 && casc_a_n_o == 1'b1, "R5 casc out",
          COLS'({casc_a_n_o, casc_b_n_o}), COLS'(2'b10));
    beat(8'hFF); beat(8'h00);
    check(casc_b_n_o == 1'b0, "R6 hold", COLS'(casc_b_n_o), '0);
    line_pulse();

    // R3 narrow mode
    wide_mode = 1'b0;
    for (int k = 0; k < 2 * NB; k++) beat(8'(k * 11 + 3));
    line_pulse();

    // R7 partial row keeps older columns
    wide_mode = 1'b1;
    for (int k = 0; k < 3; k++) beat(8'(8'hA0 + k));
    line_pulse();

    // R6 nibble phase reset by line pulse
    wide_mode = 1'b0;
    beat(8'h0C);
    line_pulse();
    beat(8'h05); beat(8'h09);
    line_pulse();

    // R4 reversed fill and swapped enable pins
    wide_mode = 1'b1; rev_dir = 1'b1; casc_a_n_i = 1'b0; casc_b_n_i = 1'b1;
    @(negedge clk); #1;
    check(!din_ready, "R4 input pin", COLS'(din_ready), '0);
    casc_b_n_i = 1'b0;
    for (int k = 0; k < NB; k++) beat(8'(k * 53 + 17));
    check(casc_a_n_o == 1'b0 && casc_b_n_o == 1'b1, "R4 output pin",
          COLS'({casc_a_n_o, casc_b_n_o}), COLS'(2'b01));
    line_pulse();

    // R8 display off clears, also across a line pulse
    @(negedge clk); disp_off_n = 1'b0;
    @(negedge clk); #1;
    check(line_q == '0, "R8 clear", line_q, '0);
    line_pulse();
    @(negedge clk); disp_off_n = 1'b1;
    line_pulse();
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule